// File: doc/BRIEF.md
# Segment Address Translation Unit

This block converts a 32-bit logical address into a physical address under a segmented memory model. The upper half of the logical address selects a segment and the lower half is a byte offset inside it. The unit looks the segment up in a table held in memory and adds the segment's start address to the offset to form the result.

Two configuration inputs describe the table: its byte address in memory and the number of entries it holds. Each entry is 8 bytes, read as two 32-bit words. The word at the lower address is the segment's start address and the word 4 bytes above it is the segment's length in bytes. A translation is checked against two limits. The first is the segment number against the table size, and it is tested before any memory access. The second is the offset against the length fetched from the entry. A violation of either limit ends the translation with a fault code instead of an address.

The unit handles one translation at a time. It uses a request/acknowledge read port toward memory that tolerates any response latency. Each result is announced by a one-cycle completion strobe.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `xl_done` is 0, `mem_rd_req` is 0 and `xl_ready` is 1.
- R2: The segment number is taken from `xl_laddr[31:16]` and the offset from `xl_laddr[15:0]`.
- R3: If the segment number is greater than or equal to `cfg_tbl_len`, the unit completes with fault code 2'b01 and issues no memory read. `xl_done` rises in the second cycle after the accepting clock edge. With `cfg_tbl_len` = 0 every request faults this way.
- R4: For an in-range segment the unit reads exactly two words. The first is at `cfg_tbl_base + 8*segment`, and its data is taken as the segment base. The second is at that address plus 4, and its data is taken as the segment length.
- R5: If the offset is greater than or equal to the fetched length, the unit completes with fault code 2'b10 and `xl_paddr` = 0. A length of 0 faults every offset.
- R6: Otherwise it completes with fault code 2'b00 and `xl_paddr` = base + offset, modulo 2^32. Segment number `cfg_tbl_len-1` and offset `length-1` are both accepted.
- R7: A request is accepted on a clock edge where `xl_valid` and `xl_ready` are both 1. `xl_ready` stays 0 from that edge until completion. `xl_done` is high for exactly one cycle per translation, and `xl_fault` is never 2'b11.
- R8: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack` is seen. `mem_rd_data` is captured in the acknowledging cycle, whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tbl_base | input | 32 | Byte address of the segment table |
| cfg_tbl_len | input | 17 | Number of valid table entries (0 to 65536) |
| xl_valid | input | 1 | Translation request |
| xl_ready | output | 1 | Unit idle and able to accept a request |
| xl_laddr | input | 32 | Logical address: segment[31:16], offset[15:0] |
| xl_done | output | 1 | One-cycle completion strobe |
| xl_fault | output | 2 | 00 success, 01 segment out of range, 10 offset out of range |
| xl_paddr | output | 32 | Physical address, 0 on a fault |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_ack | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response data |

## Verification
The checker covers the cycle-level protocol on every clock: completion strobes last one cycle, the unit refuses new work while busy, memory requests hold their address until acknowledged, the fault code is never 2'b11, a fault reports a zero address, and no read is issued while idle. Other behaviour depends on specific input values, and only the bench scenarios show it. This includes the arithmetic of the entry address and the physical address, the boundaries at the last valid segment and the last valid byte, the absence of reads on a segment fault, the zero-length segment and the empty table, and address wrap-around.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_OFF  = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEGCHK,
    ST_RD_BASE,
    ST_RD_LEN,
    ST_OFFCHK
  } state_e;

endpackage

// File: rtl/seg_xlate_bound.sv
// Unsigned limit comparator: over = (val >= lim)
module seg_xlate_bound #(
  parameter int VAL_W = 16,
  parameter int LIM_W = 17
) (
  input  logic [VAL_W-1:0] val,
  input  logic [LIM_W-1:0] lim,
  output logic             over
);
  localparam int W = (VAL_W > LIM_W) ? VAL_W : LIM_W;

  logic [W-1:0] val_x;
  logic [W-1:0] lim_x;

  assign val_x = W'(val);
  assign lim_x = W'(lim);
  assign over  = (val_x >= lim_x);
endmodule

// File: rtl/seg_xlate_addr.sv
// Table entry address: base + segment * entry size
module seg_xlate_addr #(
  parameter int SEG_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int ENT_BYTES = 8
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int ENT_SHIFT = $clog2(ENT_BYTES);

  logic [ADDR_W-1:0] seg_scaled;

  assign seg_scaled = ADDR_W'(seg) << ENT_SHIFT;
  assign ent_addr   = tbl_base + seg_scaled;
endmodule

// File: rtl/seg_xlate_ctrl.sv
// Sequencer: accept, segment check, two table reads, offset check, result
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   xl_valid,
  input  logic [SEG_W+OFF_W-1:0] xl_laddr,
  output logic                   xl_ready,
  output logic                   xl_done,
  output logic [1:0]             xl_fault,
  output logic [ADDR_W-1:0]      xl_paddr,
  output logic                   mem_rd_req,
  output logic [ADDR_W-1:0]      mem_rd_addr,
  input  logic                   mem_rd_ack,
  input  logic [DATA_W-1:0]      mem_rd_data,
  output logic [SEG_W-1:0]       seg_o,
  output logic [OFF_W-1:0]       off_o,
  output logic [DATA_W-1:0]      len_o,
  input  logic [ADDR_W-1:0]      ent_addr,
  input  logic                   seg_oob,
  input  logic                   off_oob
);
  state_e              state_q;
  logic [SEG_W-1:0]    seg_q;
  logic [OFF_W-1:0]    off_q;
  logic [DATA_W-1:0]   base_q;
  logic [DATA_W-1:0]   len_q;
  logic                req_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                done_q;
  fault_e              fault_q;
  logic [ADDR_W-1:0]   paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      off_q   <= '0;
      base_q  <= '0;
      len_q   <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (xl_valid) begin
            seg_q   <= xl_laddr[SEG_W+OFF_W-1:OFF_W];
            off_q   <= xl_laddr[OFF_W-1:0];
            state_q <= ST_SEGCHK;
          end
        end
        ST_SEGCHK: begin
          if (seg_oob) begin
            done_q  <= 1'b1;
            fault_q <= FLT_SEG;
            paddr_q <= '0;
            state_q <= ST_IDLE;
          end else begin
            req_q   <= 1'b1;
            addr_q  <= ent_addr;
            state_q <= ST_RD_BASE;
          end
        end
        ST_RD_BASE: begin
          if (mem_rd_ack) begin
            base_q  <= mem_rd_data;
            addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
            state_q <= ST_RD_LEN;
          end
        end
        ST_RD_LEN: begin
          if (mem_rd_ack) begin
            len_q   <= mem_rd_data;
            req_q   <= 1'b0;
            state_q <= ST_OFFCHK;
          end
        end
        ST_OFFCHK: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (off_oob) begin
            fault_q <= FLT_OFF;
            paddr_q <= '0;
          end else begin
            fault_q <= FLT_NONE;
            paddr_q <= ADDR_W'(base_q) + ADDR_W'(off_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xl_ready    = (state_q == ST_IDLE);
  assign xl_done     = done_q;
  assign xl_fault    = fault_q;
  assign xl_paddr    = paddr_q;
  assign mem_rd_req  = req_q;
  assign mem_rd_addr = addr_q;
  assign seg_o       = seg_q;
  assign off_o       = off_q;
  assign len_o       = len_q;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ENT_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      cfg_tbl_base,
  input  logic [SEG_W:0]         cfg_tbl_len,
  input  logic                   xl_valid,
  output logic                   xl_ready,
  input  logic [SEG_W+OFF_W-1:0] xl_laddr,
  output logic                   xl_done,
  output logic [1:0]             xl_fault,
  output logic [ADDR_W-1:0]      xl_paddr,
  output logic                   mem_rd_req,
  output logic [ADDR_W-1:0]      mem_rd_addr,
  input  logic                   mem_rd_ack,
  input  logic [DATA_W-1:0]      mem_rd_data
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] seg_len;
  logic [ADDR_W-1:0] ent_addr;
  logic              seg_oob;
  logic              off_oob;

  seg_xlate_ctrl #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .xl_valid(xl_valid), .xl_laddr(xl_laddr), .xl_ready(xl_ready),
    .xl_done(xl_done), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .seg_o(seg), .off_o(off), .len_o(seg_len),
    .ent_addr(ent_addr), .seg_oob(seg_oob), .off_oob(off_oob)
  );

  seg_xlate_addr #(
    .SEG_W(SEG_W), .ADDR_W(ADDR_W), .ENT_BYTES(ENT_BYTES)
  ) u_addr (
    .tbl_base(cfg_tbl_base), .seg(seg), .ent_addr(ent_addr)
  );

  seg_xlate_bound #(.VAL_W(SEG_W), .LIM_W(SEG_W+1)) u_seg_bound (
    .val(seg), .lim(cfg_tbl_len), .over(seg_oob)
  );

  seg_xlate_bound #(.VAL_W(OFF_W), .LIM_W(DATA_W)) u_off_bound (
    .val(off), .lim(seg_len), .over(off_oob)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              xl_valid,
  input logic              xl_ready,
  input logic              xl_done,
  input logic [1:0]        xl_fault,
  input logic [ADDR_W-1:0] xl_paddr,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    xl_done |=> !xl_done);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_ready) |=> !xl_ready);

  assert_fault_code_R7: assert property (@(posedge clk) disable iff (rst)
    xl_done |-> (xl_fault != 2'b11));

  assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (xl_done && xl_fault != 2'b00) |-> (xl_paddr == '0));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (rst)
    xl_ready |-> !mem_rd_req);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_ready(xl_ready),
  .xl_done(xl_done), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_tbl_base = 32'h40;
  logic [16:0] cfg_tbl_len  = 17'd4;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [31:0] xl_laddr = '0;
  logic        xl_done;
  logic [1:0]  xl_fault;
  logic [31:0] xl_paddr;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst(rst), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_laddr(xl_laddr),
    .xl_done(xl_done), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  // memory model: 64 words, word index = addr[7:2]
  logic [31:0] mem [0:63];
  int          lat = 0;
  int          lat_cnt = 0;
  int          n_reads = 0;
  logic [31:0] rd_log [0:3];

  always @(posedge clk) begin
    if (mem_rd_ack) begin
      mem_rd_ack <= 1'b0;
      lat_cnt    <= 0;
    end else if (mem_rd_req) begin
      if (lat_cnt >= lat) begin
        mem_rd_ack  <= 1'b1;
        mem_rd_data <= mem[mem_rd_addr[7:2]];
        if (n_reads < 4) rd_log[n_reads] <= mem_rd_addr;
        n_reads     <= n_reads + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // runs one translation; returns cycles from accept to done
  task automatic run(input logic [31:0] la, output logic [1:0] f,
                     output logic [31:0] pa, output int cyc);
    bit busy_ok = 1'b1;
    @(negedge clk);
    n_reads  = 0;
    xl_laddr = la;
    xl_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xl_valid = 1'b0;
    cyc = 1;
    while (!xl_done && cyc < 100) begin
      if (xl_ready) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    f  = xl_fault;
    pa = xl_paddr;
    check("R7 ready low while busy", {31'd0, busy_ok}, 32'd1);
    @(negedge clk);
    check("R7 done one cycle", {31'd0, xl_done}, 32'd0);
  endtask

  task automatic test_reset();
    check("R1 done at reset", {31'd0, xl_done}, 32'd0);
    check("R1 req at reset", {31'd0, mem_rd_req}, 32'd0);
    check("R1 ready at reset", {31'd0, xl_ready}, 32'd1);
  endtask

  task automatic test_basic();
    logic [1:0] f; logic [31:0] pa; int c;
    lat = 0;
    run(32'h0000_0020, f, pa, c);
    check("R6 basic fault", {30'd0, f}, 32'h0);
    check("R6 basic paddr", pa, 32'h1000_0020);
    check("R4 reads", n_reads, 2);
    check("R4 word0 addr", rd_log[0], 32'h40);
    check("R4 word1 addr", rd_log[1], 32'h44);
  endtask

  task automatic test_latency();
    logic [1:0] f; logic [31:0] pa; int c;
    lat = 3;
    run(32'h0001_ABCD, f, pa, c);
    check("R8 slow paddr", pa, 32'h2000_ABCD);
    check("R2 R4 seg1 word0 addr", rd_log[0], 32'h48);
    check("R4 seg1 word1 addr", rd_log[1], 32'h4C);
    lat = 0;
  endtask

  task automatic test_seg_fault();
    logic [1:0] f; logic [31:0] pa; int c;
    run(32'h0004_0000, f, pa, c);
    check("R3 seg==len fault", {30'd0, f}, 32'h1);
    check("R3 no reads", n_reads, 0);
    check("R3 latency", c, 2);
    run(32'hFFFF_0001, f, pa, c);
    check("R3 seg max fault", {30'd0, f}, 32'h1);
    check("R5 fault paddr zero", pa, 32'h0);
  endtask

  task automatic test_edges();
    logic [1:0] f; logic [31:0] pa; int c;
    run(32'h0003_003F, f, pa, c);
    check("R6 last seg last byte fault", {30'd0, f}, 32'h0);
    check("R6 wrap paddr", pa, 32'h0000_002F);
    run(32'h0000_0100, f, pa, c);
    check("R5 off==len fault", {30'd0, f}, 32'h2);
    check("R5 off fault paddr", pa, 32'h0);
    run(32'h0000_FFFF, f, pa, c);
    check("R5 off max fault", {30'd0, f}, 32'h2);
    run(32'h0002_0000, f, pa, c);
    check("R5 zero length fault", {30'd0, f}, 32'h2);
    run(32'h0001_FFFF, f, pa, c);
    check("R6 full-size seg", pa, 32'h2000_FFFF);
  endtask

  task automatic test_empty_table();
    logic [1:0] f; logic [31:0] pa; int c;
    cfg_tbl_len = 17'd0;
    run(32'h0000_0000, f, pa, c);
    check("R3 empty table fault", {30'd0, f}, 32'h1);
    check("R3 empty no reads", n_reads, 0);
    cfg_tbl_len = 17'd4;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    mem[16] = 32'h1000_0000; mem[17] = 32'h0000_0100;
    mem[18] = 32'h2000_0000; mem[19] = 32'h0001_0000;
    mem[20] = 32'h3000_0000; mem[21] = 32'h0000_0000;
    mem[22] = 32'hFFFF_FFF0; mem[23] = 32'h0000_0040;
    repeat (3) @(posedge clk);
    @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_latency();
    test_seg_fault();
    test_edges();
    test_empty_table();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule